// File: doc/BRIEF.md
# Four-channel PCM time-slot port

This block is the digital side of a four-channel serial PCM highway. It serves four voice channels that share one transmit data line and one receive data line, all running on the PCM bit clock. Each channel has its own transmit sync input and its own receive sync input. A sync marks where that channel's 8-bit slot falls in the 8 kHz frame, so a channel's position in a frame of up to 128 slots is set entirely by the timing of its sync.

At the start of its transmit slot a channel latches its parallel byte. It then shifts the byte onto the shared line, most significant bit first. Between slots the line is released: the output enable drops, which stands in for a high-impedance pad. A shared active-low slot strobe goes low while any channel is driving. In the receive direction the block collects eight serial bits into a parallel byte for each channel and flags the byte with a one-cycle valid pulse.

A mode input selects the sync timing. In short mode a one-clock pulse comes one clock before the slot. In long mode the slot begins together with the rising edge of a sync held high. A channel whose power-down input is high ignores its syncs. If two transmit slots overlap, the lowest-numbered channel keeps the line and a clash flag is raised.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is asserted and after it is released with no syncs, `dx_oe` is 0, `dx` is 0, `tsc_n` is 1, `rx_valid` is all zeros and `tx_clash` is 0.
- R2: Short mode (`long_mode`=0): when channel n's `fsx` bit is sampled high at clock edge E after being low at edge E-1, the channel drives bit 7 of its byte in the cycle after edge E+1, then bits 6 down to 0 in the next seven cycles.
- R3: Long mode (`long_mode`=1): when channel n's `fsx` bit is sampled high at edge E after being low at edge E-1, the channel drives bit 7 in the cycle after edge E, then bits 6 down to 0 in the next seven cycles. The sync may stay high for several clocks.
- R4: `dx_oe` is 1 exactly while some channel is inside its 8-cycle transmit slot, and `dx` reads 0 whenever `dx_oe` is 0.
- R5: `tsc_n` is low exactly while `dx_oe` is high.
- R6: The transmit byte, taken from bits [8n+7:8n] of `tx_byte`, is latched at the edge that begins the slot. Later changes to `tx_byte` do not alter the bits shifted out in that slot.
- R7: The receive slot begins at the same edge, relative to `fsr`, that a transmit slot would begin relative to `fsx`. `dr` is sampled at the eight edges after the start edge, first bit into bit 7. After the eighth sample, bits [8n+7:8n] of `rx_byte` hold the byte and `rx_valid[n]` is high for exactly one cycle.
- R8: While `pdn[n]` is 1, channel n ignores its syncs: it never drives `dx` or `dx_oe` and never raises `rx_valid[n]`. Raising `pdn[n]` during a slot ends that slot at the next edge.
- R9: When two or more transmit slots overlap, `dx` carries the bit of the lowest-numbered active channel, and `tx_clash` is 1 in exactly those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock; all logic uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_mode | input | 1 | 1 selects long sync timing, 0 selects short |
| pdn | input | NCH | Per-channel standby, active high |
| fsx | input | NCH | Per-channel transmit slot sync |
| fsr | input | NCH | Per-channel receive slot sync |
| tx_byte | input | NCH*W | Parallel transmit bytes, channel n at [n*W +: W] |
| dr | input | 1 | Shared serial receive data |
| dx | output | 1 | Shared serial transmit data |
| dx_oe | output | 1 | Transmit drive enable (low means high impedance) |
| tsc_n | output | 1 | Active-low slot strobe |
| rx_byte | output | NCH*W | Last received byte per channel |
| rx_valid | output | NCH | One-cycle pulse per channel when its byte is new |
| tx_clash | output | 1 | High while transmit slots of two or more channels overlap |

## Verification
The bench builds the port with its defaults of four channels and 8-bit samples. At that size every sync line, every priority pairing in an overlap, and the full slot length in both sync modes can be driven within a few thousand cycles. A behavioural model based on slot start times predicts `dx`, `dx_oe`, `tsc_n`, `tx_clash` and the receive outputs on every clock, while pseudo-random serial and parallel data run through the port. Directed passes then cover adjacent slots, overlap, changing the parallel byte in mid-slot, and power-down both before and during a slot.

// File: rtl/pcm_slot_port.sv
module pcm_slot_port #(
  parameter int NCH = 4,
  parameter int W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             long_mode,
  input  logic [NCH-1:0]   pdn,
  input  logic [NCH-1:0]   fsx,
  input  logic [NCH-1:0]   fsr,
  input  logic [NCH*W-1:0] tx_byte,
  input  logic             dr,
  output logic             dx,
  output logic             dx_oe,
  output logic             tsc_n,
  output logic [NCH*W-1:0] rx_byte,
  output logic [NCH-1:0]   rx_valid,
  output logic             tx_clash
);
  localparam int CW = $clog2(W + 1);

  logic [NCH-1:0] fsx_q, fsx_qq, fsr_q, fsr_qq;
  logic [NCH-1:0] tx_go, rx_go, tx_on, tx_bit;
  logic           sel_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsx_q  <= '0;
      fsx_qq <= '0;
      fsr_q  <= '0;
      fsr_qq <= '0;
    end else begin
      fsx_q  <= fsx;
      fsx_qq <= fsx_q;
      fsr_q  <= fsr;
      fsr_qq <= fsr_q;
    end
  end

  assign tx_go = long_mode ? (fsx & ~fsx_q) : (fsx_q & ~fsx_qq);
  assign rx_go = long_mode ? (fsr & ~fsr_q) : (fsr_q & ~fsr_qq);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [W-1:0]  tsr, rsr, rhold;
    logic [CW-1:0] tcnt, rcnt;
    logic          rv;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tsr  <= '0;
        tcnt <= '0;
      end else if (pdn[g]) begin
        tcnt <= '0;
      end else if (tx_go[g]) begin
        tsr  <= tx_byte[g*W +: W];
        tcnt <= CW'(W);
      end else if (tcnt != '0) begin
        tsr  <= tsr << 1;
        tcnt <= tcnt - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rsr   <= '0;
        rcnt  <= '0;
        rhold <= '0;
        rv    <= 1'b0;
      end else if (pdn[g]) begin
        rcnt <= '0;
        rv   <= 1'b0;
      end else if (rx_go[g]) begin
        rcnt <= CW'(W);
        rv   <= 1'b0;
      end else if (rcnt != '0) begin
        rsr  <= {rsr[W-2:0], dr};
        rcnt <= rcnt - 1'b1;
        rv   <= (rcnt == CW'(1));
        if (rcnt == CW'(1)) rhold <= {rsr[W-2:0], dr};
      end else begin
        rv <= 1'b0;
      end
    end

    assign tx_on[g]             = (tcnt != '0);
    assign tx_bit[g]            = tsr[W-1];
    assign rx_byte[g*W +: W]    = rhold;
    assign rx_valid[g]          = rv;
  end

  always_comb begin
    sel_bit = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (tx_on[i]) sel_bit = tx_bit[i];
  end

  assign dx_oe    = |tx_on;
  assign dx       = dx_oe & sel_bit;
  assign tsc_n    = ~dx_oe;
  assign tx_clash = ($countones(tx_on) > 1);
endmodule

module pcm_slot_port_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           long_mode,
  input logic [NCH-1:0] pdn,
  input logic [NCH-1:0] fsx,
  input logic           dx,
  input logic           dx_oe,
  input logic [NCH-1:0] rx_valid,
  input logic           tx_clash
);
  AST_SHORT_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_mode && $past(fsx[0]) && !$past(fsx[0], 2) && !pdn[0]) |=> dx_oe); // R2
  AST_LONG_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (long_mode && fsx[0] && !$past(fsx[0]) && !pdn[0]) |=> dx_oe); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dx_oe |-> !dx); // R4
  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid[0] |=> !rx_valid[0]); // R7
  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (&pdn) |=> (!dx_oe && rx_valid == '0)); // R8
  AST_CLASH_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clash |-> dx_oe); // R9
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .pdn(pdn), .fsx(fsx),
  .dx(dx), .dx_oe(dx_oe), .rx_valid(rx_valid), .tx_clash(tx_clash)
);

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        long_mode = 1'b0;
  logic [3:0]  pdn = '0, fsx = '0, fsr = '0;
  logic [31:0] tx_byte = '0;
  logic        dr, dx, dx_oe, tsc_n, tx_clash;
  logic [31:0] rx_byte;
  logic [3:0]  rx_valid;
  logic [15:0] lf = 16'hACE1;
  int          errors = 0, checks = 0;

  pcm_slot_port u_dut (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode), .pdn(pdn), .fsx(fsx),
    .fsr(fsr), .tx_byte(tx_byte), .dr(dr), .dx(dx), .dx_oe(dx_oe),
    .tsc_n(tsc_n), .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_clash(tx_clash)
  );

  always #10 clk = ~clk;
  always @(negedge clk) lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  assign dr = lf[0];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: slot start times per channel
  int         cyc = 0;
  int         ts[4], rs[4];
  logic [7:0] tw[4], racc[4], erx[4];
  logic [3:0] ev, h1x, h2x, h1r, h2r;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        ts[i] = -100; rs[i] = -100; erx[i] = '0; racc[i] = '0;
      end
      ev = '0; h1x = '0; h2x = '0; h1r = '0; h2r = '0;
    end else begin
      cyc++;
      for (int i = 0; i < 4; i++) begin
        logic gox, gor;
        gox = long_mode ? (fsx[i] & ~h1x[i]) : (h1x[i] & ~h2x[i]);
        gor = long_mode ? (fsr[i] & ~h1r[i]) : (h1r[i] & ~h2r[i]);
        if (pdn[i]) ts[i] = -100;
        else if (gox) begin ts[i] = cyc; tw[i] = tx_byte[i*8 +: 8]; end
        ev[i] = 1'b0;
        if (pdn[i]) rs[i] = -100;
        else if (gor) rs[i] = cyc;
        else if (cyc - rs[i] >= 1 && cyc - rs[i] <= 8) begin
          racc[i] = {racc[i][6:0], dr};
          if (cyc - rs[i] == 8) begin ev[i] = 1'b1; erx[i] = racc[i]; end
        end
      end
      h2x = h1x; h1x = fsx; h2r = h1r; h1r = fsr;
      #5;
      begin
        logic eoe, edx;
        int   n;
        eoe = 1'b0; edx = 1'b0; n = 0;
        for (int i = 3; i >= 0; i--)
          if (cyc - ts[i] >= 0 && cyc - ts[i] < 8) begin
            n++; eoe = 1'b1; edx = tw[i][7 - (cyc - ts[i])];
          end
        chk("R4 dx_oe", 32'(dx_oe), 32'(eoe));
        chk("R5 tsc_n", 32'(tsc_n), 32'(!eoe));
        if (long_mode) chk("R3 dx", 32'(dx), 32'(edx));
        else           chk("R2 dx", 32'(dx), 32'(edx));
        chk("R9 tx_clash", 32'(tx_clash), 32'(n > 1));
        chk("R7 rx_valid", 32'(rx_valid), 32'(ev));
        chk("R7 rx_byte", rx_byte, {erx[3], erx[2], erx[1], erx[0]});
      end
    end
  end

  task automatic step(input logic [3:0] fx, input logic [3:0] fr);
    @(negedge clk);
    fsx = fx; fsr = fr;
  endtask

  task automatic idle(input int n);
    repeat (n) step(4'b0, 4'b0);
  endtask

  task automatic pulse(input logic [3:0] fx, input logic [3:0] fr, input int len);
    tx_byte = {lf, lf ^ 16'h5A3C};
    repeat (len) step(fx, fr);
    step(4'b0, 4'b0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] acc;
    repeat (3) @(negedge clk);
    chk("R1 dx_oe", 32'(dx_oe), 0);
    chk("R1 dx", 32'(dx), 0);
    chk("R1 tsc_n", 32'(tsc_n), 1);
    chk("R1 rx_valid", 32'(rx_valid), 0);
    chk("R1 tx_clash", 32'(tx_clash), 0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 idle dx_oe", 32'(dx_oe), 0);

    // each channel in turn, both sync modes, rx on a rotated channel
    for (int m = 0; m < 2; m++) begin
      long_mode = m[0];
      for (int r = 0; r < 6; r++)
        for (int c = 0; c < 4; c++) begin
          pulse(4'b1 << c, 4'b1 << ((c + r) % 4), m ? 3 : 1);
          idle(10);
        end
      // abutting slots: next sync eight cycles after the previous
      for (int c = 0; c < 4; c++) begin
        tx_byte = {lf, ~lf};
        step(4'b1 << c, 4'b1 << c);
        idle(7);
      end
      idle(10);
      // overlaps
      pulse(4'b0110, 4'b0110, m ? 2 : 1); idle(10);
      pulse(4'b1111, 4'b0000, m ? 2 : 1); idle(10);
      pulse(4'b1000, 4'b0, 1); idle(3); pulse(4'b0001, 4'b0, 1); idle(12);
    end

    // R6: byte latched at slot start
    long_mode = 1'b0;
    tx_byte[7:0] = 8'hA5;
    step(4'b0001, 4'b0);
    step(4'b0, 4'b0);
    acc = '0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #5;
      acc = {acc[6:0], dx};
      if (k == 0) tx_byte[7:0] = 8'h00;
    end
    chk("R6 latched byte", 32'(acc), 32'hA5);
    idle(6);

    // R8: standby channel ignores syncs
    pdn = 4'b0100;
    step(4'b0100, 4'b0100);
    step(4'b0, 4'b0);
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #5;
      chk("R8 standby dx_oe", 32'(dx_oe), 0);
      chk("R8 standby rx_valid", 32'(rx_valid[2]), 0);
    end
    // R8: power-down during a slot
    pdn = 4'b0000;
    step(4'b1000, 4'b1000);
    step(4'b0, 4'b0);
    repeat (3) @(posedge clk);
    #5 pdn = 4'b1000;
    @(posedge clk); #5;
    chk("R8 abort dx_oe", 32'(dx_oe), 0);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #5;
      chk("R8 abort rx_valid", 32'(rx_valid[3]), 0);
    end
    pdn = 4'b0000;
    long_mode = 1'b1;
    pulse(4'b0010, 4'b0010, 4); idle(12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule